// File: doc/BRIEF.md
# Video Input Loss Detector

The detector watches an incoming video stream and reports when the stream stops being trustworthy. Four independent checks run on the stream. A runaway check catches a line that never ends. A line-length check catches a line whose count of active data words differs from the reference line. A vertical check catches a frame with too many lines, or a data word written past a programmed address ceiling. A clock watchdog catches a video pixel clock that has stopped.

Each check raises its own sticky pending bit in the system clock domain, but only while its enable bit is set. The `video_ok` output is high only while no pending bit is set. Software clears a pending bit by writing one to it. `video_ok` therefore stays low after the fault has gone, until the cause has been acknowledged.

The line, frame, data and address inputs belong to the pixel clock domain. Events found there are carried into the system domain by toggle handshakes. The watchdog works without any pixel-domain logic on its counting path: the system domain sends a toggle request, the pixel clock echoes it back, and each echo that arrives restarts a count of system clocks.

Top module: `vld_loss_detect`

## Requirements
- R1: After reset `pend` is 0, `video_ok` is 1 and `line_abort` is 0.
- R2: The enable bits map as follows: bit 3 is the runaway check, bit 2 the vertical/address check, bit 1 the line-length check and bit 0 the clock watchdog. The same positions are used in `pend` and `pend_clr`. A check whose enable bit is 0 never sets its pending bit. `line_abort` never pulses while bit 3 is 0.
- R3: Suppose `line_start` is sampled at a pixel edge and is not sampled again in the next RUN_LIMIT pixel edges. At the RUN_LIMIT-th of those edges the line is aborted: `line_abort` goes high for exactly one pixel clock and `pend[3]` is set. A line of RUN_LIMIT clocks or fewer never aborts.
- R4: An aborted line ends the current line. The next `line_start` opens a new line without comparing the data count of the aborted line.
- R5: The data count of a line is the number of pixel edges at which `data_valid` is sampled high, counted from its `line_start` edge up to (but not including) the next `line_start` edge. The first complete line after reset, or after a mismatch, becomes the reference. Any later complete line with a different count sets `pend[1]` and discards the reference.
- R6: Counting from the last `frame_start`, where the `line_start` in the same cycle as `frame_start` is line 1, the line after line `vert_lines` sets `pend[2]`.
- R7: A data word with `pix_addr` greater than `max_addr` sets `pend[2]`. A word whose address equals `max_addr` does not.
- R8: When WD_LIMIT system clocks pass with no echo of the pixel clock, `pend[0]` is set once for that loss. A running pixel clock never sets it.
- R9: A pending bit stays set until a one is written to the same position of `pend_clr`. Clearing one bit leaves the others unchanged.
- R10: `video_ok` is low whenever any pending bit is set. It rises only in the cycle after a `pend_clr` write that empties `pend`, even when the fault has already gone away.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| sys_clk | input | 1 | System clock: pending bits and watchdog |
| pix_clk | input | 1 | Video pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously in each domain |
| chk_en | input | 4 | Check enables (bit 3 runaway, bit 2 vertical/address, bit 1 line length, bit 0 clock loss) |
| pend_clr | input | 4 | Write-one-to-clear strobes for the pending bits (system domain) |
| line_start | input | 1 | Strobe at the first pixel clock of each line |
| frame_start | input | 1 | Strobe at the first pixel clock of each frame |
| data_valid | input | 1 | Active data word present this pixel clock |
| pix_addr | input | ADDR_W | Destination address of the current data word |
| vert_lines | input | VCNT_W | Programmed number of lines per frame |
| max_addr | input | ADDR_W | Programmed highest legal address |
| pend | output | 4 | Sticky pending bits, same positions as `chk_en` |
| video_ok | output | 1 | High while no pending bit is set |
| line_abort | output | 1 | One pixel-clock pulse when a runaway line is aborted |

## Verification
A wrong line-clock counter shows up at the ports as a `line_abort` pulse one pixel clock early or late, or as a missing pulse, at the boundary line lengths RUN_LIMIT and RUN_LIMIT+1. A stale or lost reference length shows up as a `pend[1]` bit set, or not set, within a few lines of the mismatch. Faults in the handshakes or in the watchdog show up only after the crossing latency: a `pend` bit that is missing or spurious a handful of system clocks after the event, or a clock-loss bit that fails to rise within WD_LIMIT plus a few cycles of the clock stopping. Because every bit is sticky, a wrong set is visible on `video_ok` until the next clear.

// File: rtl/vld_pkg.sv
package vld_pkg;
  localparam int NCHK     = 4;
  localparam int CHK_RUN  = 3;
  localparam int CHK_VERT = 2;
  localparam int CHK_LEN  = 1;
  localparam int CHK_CLK  = 0;
endpackage

// File: rtl/vld_rst_sync.sv
module vld_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n_o
);
  logic [1:0] stage_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) stage_q <= 2'b00;
    else         stage_q <= {stage_q[0], 1'b1};
  end

  assign rst_n_o = stage_q[1];
endmodule

// File: rtl/vld_pix_checks.sv
module vld_pix_checks #(
  parameter int RUN_LIMIT = 3000,
  parameter int ADDR_W    = 24,
  parameter int VCNT_W    = 11,
  parameter int DCNT_W    = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run_en,
  input  logic              line_start,
  input  logic              frame_start,
  input  logic              data_valid,
  input  logic [ADDR_W-1:0] pix_addr,
  input  logic [VCNT_W-1:0] vert_lines,
  input  logic [ADDR_W-1:0] max_addr,
  output logic              line_abort,
  output logic              run_evt,
  output logic              len_evt,
  output logic              vert_evt
);
  localparam int RUN_W = (RUN_LIMIT > 2) ? $clog2(RUN_LIMIT) : 1;
  localparam logic [RUN_W-1:0] RUN_LAST = RUN_W'(RUN_LIMIT - 1);

  // line timing state
  logic             in_line_q, in_line_d;
  logic [RUN_W-1:0] run_cnt_q, run_cnt_d;
  logic             abort_q, abort_d;

  // line length state
  logic [DCNT_W-1:0] dcnt_q, dcnt_d;
  logic [DCNT_W-1:0] ref_q;
  logic              ref_vld_q, ref_vld_d;
  logic              ref_ld;

  // vertical state
  logic [VCNT_W-1:0] vcnt_q, vcnt_d;
  logic              line_over, addr_over;

  // runaway line detection
  always_comb begin
    in_line_d = in_line_q;
    run_cnt_d = run_cnt_q;
    abort_d   = 1'b0;
    run_evt   = 1'b0;
    if (line_start) begin
      in_line_d = 1'b1;
      run_cnt_d = '0;
    end else if (in_line_q) begin
      if (run_cnt_q == RUN_LAST) begin
        in_line_d = 1'b0;
        run_evt   = 1'b1;
        abort_d   = run_en;
      end else begin
        run_cnt_d = run_cnt_q + RUN_W'(1);
      end
    end
  end

  // active data count per line against the captured reference
  always_comb begin
    dcnt_d    = dcnt_q;
    ref_vld_d = ref_vld_q;
    ref_ld    = 1'b0;
    len_evt   = 1'b0;
    if (line_start) begin
      dcnt_d = data_valid ? DCNT_W'(1) : '0;
      if (in_line_q) begin
        if (!ref_vld_q) begin
          ref_ld    = 1'b1;
          ref_vld_d = 1'b1;
        end else if (dcnt_q != ref_q) begin
          len_evt   = 1'b1;
          ref_vld_d = 1'b0;
        end
      end
    end else if (data_valid && (dcnt_q != '1)) begin
      dcnt_d = dcnt_q + DCNT_W'(1);
    end
  end

  // lines per frame and address ceiling
  always_comb begin
    vcnt_d    = vcnt_q;
    line_over = 1'b0;
    if (frame_start) begin
      vcnt_d = line_start ? VCNT_W'(1) : '0;
    end else if (line_start) begin
      if (vcnt_q >= vert_lines) line_over = 1'b1;
      else                      vcnt_d    = vcnt_q + VCNT_W'(1);
    end
    addr_over = data_valid && (pix_addr > max_addr);
    vert_evt  = line_over | addr_over;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      in_line_q <= 1'b0;
      run_cnt_q <= '0;
      abort_q   <= 1'b0;
      dcnt_q    <= '0;
      ref_vld_q <= 1'b0;
      vcnt_q    <= '0;
    end else begin
      in_line_q <= in_line_d;
      run_cnt_q <= run_cnt_d;
      abort_q   <= abort_d;
      dcnt_q    <= dcnt_d;
      ref_vld_q <= ref_vld_d;
      vcnt_q    <= vcnt_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      ref_q <= '0;
    else if (ref_ld) ref_q <= dcnt_q;
  end

  assign line_abort = abort_q;
endmodule

// File: rtl/vld_evt_cdc.sv
module vld_evt_cdc (
  input  logic src_clk,
  input  logic src_rst_n,
  input  logic src_evt,
  input  logic dst_clk,
  input  logic dst_rst_n,
  output logic dst_evt
);
  logic       tog_q, tog_d;
  logic [1:0] ack_sync_q;
  logic [1:0] tog_sync_q;
  logic       seen_q;
  logic       idle;

  // source side: toggle only once the previous toggle has been seen
  always_comb begin
    idle  = (ack_sync_q[1] == tog_q);
    tog_d = (src_evt && idle) ? ~tog_q : tog_q;
  end

  always_ff @(posedge src_clk or negedge src_rst_n) begin
    if (!src_rst_n) begin
      tog_q      <= 1'b0;
      ack_sync_q <= 2'b00;
    end else begin
      tog_q      <= tog_d;
      ack_sync_q <= {ack_sync_q[0], seen_q};
    end
  end

  // destination side: edge of the synchronized toggle is the event
  always_ff @(posedge dst_clk or negedge dst_rst_n) begin
    if (!dst_rst_n) begin
      tog_sync_q <= 2'b00;
      seen_q     <= 1'b0;
    end else begin
      tog_sync_q <= {tog_sync_q[0], tog_q};
      seen_q     <= tog_sync_q[1];
    end
  end

  assign dst_evt = tog_sync_q[1] ^ seen_q;
endmodule

// File: rtl/vld_clk_watch.sv
module vld_clk_watch #(
  parameter int WD_LIMIT = 128
) (
  input  logic sys_clk,
  input  logic sys_rst_n,
  input  logic pix_clk,
  input  logic pix_rst_n,
  output logic lost_evt
);
  localparam int WD_W = $clog2(WD_LIMIT + 1);
  localparam logic [WD_W-1:0] WD_LAST = WD_W'(WD_LIMIT - 1);
  localparam logic [WD_W-1:0] WD_SAT  = WD_W'(WD_LIMIT);

  logic            req_q, req_d;
  logic [1:0]      echo_sync_q;
  logic [1:0]      ack_sync_q;
  logic            ack_prev_q;
  logic            activity;
  logic [WD_W-1:0] wd_cnt_q, wd_cnt_d;
  logic            wd_en;

  // pixel side: echo the request back through two flops
  always_ff @(posedge pix_clk or negedge pix_rst_n) begin
    if (!pix_rst_n) echo_sync_q <= 2'b00;
    else            echo_sync_q <= {echo_sync_q[0], req_q};
  end

  always_comb begin
    activity = ack_sync_q[1] ^ ack_prev_q;
    req_d    = (ack_sync_q[1] == req_q) ? ~req_q : req_q;
    wd_en    = activity || (wd_cnt_q != WD_SAT);
    wd_cnt_d = activity ? '0 : wd_cnt_q + WD_W'(1);
    lost_evt = !activity && (wd_cnt_q == WD_LAST);
  end

  always_ff @(posedge sys_clk or negedge sys_rst_n) begin
    if (!sys_rst_n) begin
      req_q      <= 1'b0;
      ack_sync_q <= 2'b00;
      ack_prev_q <= 1'b0;
    end else begin
      req_q      <= req_d;
      ack_sync_q <= {ack_sync_q[0], echo_sync_q[1]};
      ack_prev_q <= ack_sync_q[1];
    end
  end

  always_ff @(posedge sys_clk or negedge sys_rst_n) begin
    if (!sys_rst_n) wd_cnt_q <= '0;
    else if (wd_en) wd_cnt_q <= wd_cnt_d;
  end
endmodule

// File: rtl/vld_loss_detect.sv
module vld_loss_detect
  import vld_pkg::*;
#(
  parameter int RUN_LIMIT = 3000,
  parameter int WD_LIMIT  = 128,
  parameter int ADDR_W    = 24,
  parameter int VCNT_W    = 11,
  parameter int DCNT_W    = 12
) (
  input  logic              sys_clk,
  input  logic              pix_clk,
  input  logic              rst_n,
  input  logic [NCHK-1:0]   chk_en,
  input  logic [NCHK-1:0]   pend_clr,
  input  logic              line_start,
  input  logic              frame_start,
  input  logic              data_valid,
  input  logic [ADDR_W-1:0] pix_addr,
  input  logic [VCNT_W-1:0] vert_lines,
  input  logic [ADDR_W-1:0] max_addr,
  output logic [NCHK-1:0]   pend,
  output logic              video_ok,
  output logic              line_abort
);
  logic            sys_rst_n_s;
  logic            pix_rst_n_s;
  logic [NCHK-1:1] pix_evt;
  logic [NCHK-1:0] sys_evt;
  logic [NCHK-1:0] pend_q, pend_d;
  logic            pend_we;

  vld_rst_sync u_rst_sys (.clk(sys_clk), .arst_n(rst_n), .rst_n_o(sys_rst_n_s));
  vld_rst_sync u_rst_pix (.clk(pix_clk), .arst_n(rst_n), .rst_n_o(pix_rst_n_s));

  vld_pix_checks #(
    .RUN_LIMIT(RUN_LIMIT), .ADDR_W(ADDR_W), .VCNT_W(VCNT_W), .DCNT_W(DCNT_W)
  ) u_pix (
    .clk         (pix_clk),
    .rst_n       (pix_rst_n_s),
    .run_en      (chk_en[CHK_RUN]),
    .line_start  (line_start),
    .frame_start (frame_start),
    .data_valid  (data_valid),
    .pix_addr    (pix_addr),
    .vert_lines  (vert_lines),
    .max_addr    (max_addr),
    .line_abort  (line_abort),
    .run_evt     (pix_evt[CHK_RUN]),
    .len_evt     (pix_evt[CHK_LEN]),
    .vert_evt    (pix_evt[CHK_VERT])
  );

  for (genvar g = 1; g < NCHK; g++) begin : g_cdc
    vld_evt_cdc u_cdc (
      .src_clk   (pix_clk),
      .src_rst_n (pix_rst_n_s),
      .src_evt   (pix_evt[g]),
      .dst_clk   (sys_clk),
      .dst_rst_n (sys_rst_n_s),
      .dst_evt   (sys_evt[g])
    );
  end

  vld_clk_watch #(.WD_LIMIT(WD_LIMIT)) u_watch (
    .sys_clk   (sys_clk),
    .sys_rst_n (sys_rst_n_s),
    .pix_clk   (pix_clk),
    .pix_rst_n (pix_rst_n_s),
    .lost_evt  (sys_evt[CHK_CLK])
  );

  // sticky pending bits: an enabled event wins over a clear in the same cycle
  always_comb begin
    pend_d  = (pend_q & ~pend_clr) | (sys_evt & chk_en);
    pend_we = |(pend_clr | (sys_evt & chk_en));
  end

  always_ff @(posedge sys_clk or negedge sys_rst_n_s) begin
    if (!sys_rst_n_s) pend_q <= '0;
    else if (pend_we) pend_q <= pend_d;
  end

  assign pend     = pend_q;
  assign video_ok = ~|pend_q;
endmodule

// File: rtl/vld_loss_detect_chk.sv
module vld_loss_detect_chk (
  input logic       sys_clk,
  input logic       sys_rst_n,
  input logic       pix_clk,
  input logic       pix_rst_n,
  input logic [3:0] chk_en,
  input logic [3:0] pend_clr,
  input logic [3:0] pend,
  input logic       video_ok,
  input logic       line_abort
);
  assert_set_needs_en_R2: assert property (@(posedge sys_clk) disable iff (!sys_rst_n)
    ((pend & ~$past(pend) & ~$past(chk_en)) == 4'b0000));

  assert_abort_needs_en_R2: assert property (@(posedge pix_clk) disable iff (!pix_rst_n)
    line_abort |-> $past(chk_en[3]));

  assert_abort_one_cycle_R3: assert property (@(posedge pix_clk) disable iff (!pix_rst_n)
    line_abort |=> !line_abort);

  assert_sticky_w1c_R9: assert property (@(posedge sys_clk) disable iff (!sys_rst_n)
    (($past(pend) & ~pend & ~$past(pend_clr)) == 4'b0000));

  assert_ok_rise_on_clear_R10: assert property (@(posedge sys_clk) disable iff (!sys_rst_n)
    $rose(video_ok) |-> $past(|pend_clr));
endmodule

bind vld_loss_detect vld_loss_detect_chk u_chk (
  .sys_clk    (sys_clk),
  .sys_rst_n  (sys_rst_n_s),
  .pix_clk    (pix_clk),
  .pix_rst_n  (pix_rst_n_s),
  .chk_en     (chk_en),
  .pend_clr   (pend_clr),
  .pend       (pend),
  .video_ok   (video_ok),
  .line_abort (line_abort)
);

// File: tb/vld_loss_detect_tb.sv
module vld_loss_detect_tb;
  localparam int RUN_LIMIT = 20;
  localparam int WD_LIMIT  = 32;
  localparam int ADDR_W    = 8;
  localparam int VCNT_W    = 4;
  localparam int DCNT_W    = 6;

  logic              sys_clk = 1'b0;
  logic              pix_clk = 1'b0;
  logic              pix_run = 1'b1;
  logic              rst_n;
  logic [3:0]        chk_en;
  logic [3:0]        pend_clr;
  logic              line_start, frame_start, data_valid;
  logic [ADDR_W-1:0] pix_addr, max_addr;
  logic [VCNT_W-1:0] vert_lines;
  logic [3:0]        pend;
  logic              video_ok, line_abort;

  int checks = 0;
  int errs   = 0;
  int last_aborts;

  // 125 MHz system clock; pixel clock 100 MHz, gateable
  initial forever #4 sys_clk = ~sys_clk;
  initial begin
    #2;
    forever begin
      if (pix_run) pix_clk = ~pix_clk;
      #5;
    end
  end

  vld_loss_detect #(
    .RUN_LIMIT(RUN_LIMIT), .WD_LIMIT(WD_LIMIT), .ADDR_W(ADDR_W),
    .VCNT_W(VCNT_W), .DCNT_W(DCNT_W)
  ) u_dut (
    .sys_clk(sys_clk), .pix_clk(pix_clk), .rst_n(rst_n),
    .chk_en(chk_en), .pend_clr(pend_clr),
    .line_start(line_start), .frame_start(frame_start), .data_valid(data_valid),
    .pix_addr(pix_addr), .vert_lines(vert_lines), .max_addr(max_addr),
    .pend(pend), .video_ok(video_ok), .line_abort(line_abort)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // one line of len pixel clocks, nd data words from the line_start cycle
  task automatic run_line(input int len, input int nd, input bit fr, input int addr);
    line_start  = 1'b1;
    frame_start = fr;
    data_valid  = (nd > 0);
    pix_addr    = ADDR_W'(addr);
    last_aborts = 0;
    for (int j = 1; j <= len; j++) begin
      @(negedge pix_clk);
      line_start  = 1'b0;
      frame_start = 1'b0;
      data_valid  = (j < nd);
      if (line_abort) last_aborts++;
    end
  endtask

  task automatic fill(input int k);
    for (int i = 0; i < k; i++) run_line(10, 3, 1'b1, 0);
  endtask

  task automatic sys_clear(input logic [3:0] mask);
    @(negedge sys_clk);
    pend_clr = mask;
    @(negedge sys_clk);
    pend_clr = 4'b0000;
    @(negedge pix_clk);
  endtask

  initial begin
    repeat (150000) @(posedge sys_clk);
    errs++;
    $display("FAIL R1 watchdog actual=running expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errs);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    chk_en = 4'hF; pend_clr = 4'h0;
    line_start = 1'b0; frame_start = 1'b0; data_valid = 1'b0;
    pix_addr = '0; max_addr = ADDR_W'(100); vert_lines = VCNT_W'(15);
    repeat (5) @(negedge sys_clk);
    rst_n = 1'b1;
    repeat (60) @(negedge pix_clk);

    // R1 reset state (watchdog running with live clock, no line yet)
    chk("R1 pend", pend, 4'h0);
    chk("R1 video_ok", video_ok, 1);
    chk("R1 line_abort", line_abort, 0);

    fill(3);

    // R3/R4 runaway sweep around the limit; aborted lines carry a different count
    for (int len = RUN_LIMIT - 2; len <= RUN_LIMIT + 2; len++) begin
      bit over;
      over = (len > RUN_LIMIT);
      run_line(len, over ? 6 : 3, 1'b1, 0);
      chk($sformatf("R3 abort pulses len=%0d", len), last_aborts, over ? 1 : 0);
      fill(4);
      chk($sformatf("R3 R4 pend len=%0d", len), pend, over ? 4'b1000 : 4'b0000);
      chk($sformatf("R10 video_ok len=%0d", len), video_ok, over ? 0 : 1);
      sys_clear(4'hF);
      fill(1);
    end

    // R5 line-length sweep against reference 3
    for (int nd = 1; nd <= 5; nd++) begin
      run_line(10, nd, 1'b1, 0);
      fill(4);
      chk($sformatf("R5 pend nd=%0d", nd), pend, (nd != 3) ? 4'b0010 : 4'b0000);
      sys_clear(4'hF);
      fill(1);
    end

    // R5 recapture after a mismatch
    for (int i = 0; i < 4; i++) run_line(10, 5, 1'b1, 0);
    chk("R5 single mismatch then recapture", pend, 4'b0010);
    sys_clear(4'hF);
    for (int i = 0; i < 4; i++) run_line(10, 5, 1'b1, 0);
    chk("R5 new reference holds", pend, 4'b0000);
    fill(4);
    chk("R5 change back mismatches", pend, 4'b0010);
    sys_clear(4'hF);
    fill(2);

    // R6 lines per frame sweep with vert_lines = 4
    vert_lines = VCNT_W'(4);
    for (int n = 3; n <= 6; n++) begin
      run_line(10, 3, 1'b1, 0);
      for (int i = 1; i < n; i++) run_line(10, 3, 1'b0, 0);
      fill(4);
      chk($sformatf("R6 pend lines=%0d", n), pend, (n > 4) ? 4'b0100 : 4'b0000);
      sys_clear(4'hF);
      fill(1);
    end
    vert_lines = VCNT_W'(15);

    // R7 address ceiling sweep, max_addr = 100
    for (int a = 99; a <= 101; a++) begin
      run_line(10, 3, 1'b1, a);
      fill(4);
      chk($sformatf("R7 pend addr=%0d", a), pend, (a > 100) ? 4'b0100 : 4'b0000);
      sys_clear(4'hF);
      fill(1);
    end

    // R2 all checks disabled: runaway, mismatch and bad address leave no trace
    chk_en = 4'h0;
    run_line(RUN_LIMIT + 3, 6, 1'b1, 0);
    chk("R2 no abort when disabled", last_aborts, 0);
    fill(1);
    run_line(10, 5, 1'b1, 120);
    fill(4);
    chk("R2 pend stays clear", pend, 4'h0);
    chk("R2 video_ok stays high", video_ok, 1);
    chk_en = 4'hF;
    fill(2);

    // R9/R10 two bits set, cleared one at a time
    run_line(RUN_LIMIT + 3, 6, 1'b1, 0);
    fill(1);
    run_line(10, 5, 1'b1, 0);
    fill(4);
    chk("R9 two bits set", pend, 4'b1010);
    sys_clear(4'b0010);
    chk("R9 partial clear", pend, 4'b1000);
    chk("R10 still low after partial clear", video_ok, 0);
    sys_clear(4'b1000);
    chk("R10 high after last clear", video_ok, 1);
    fill(2);

    // R8 clock loss, R10 stays low after recovery until cleared
    pix_run = 1'b0;
    repeat (80) @(negedge sys_clk);
    chk("R8 clock loss flagged", pend, 4'b0001);
    chk("R10 low on clock loss", video_ok, 0);
    pix_run = 1'b1;
    @(negedge pix_clk);
    fill(8);
    chk("R8 once per loss", pend, 4'b0001);
    chk("R10 low after recovery", video_ok, 0);
    sys_clear(4'b0001);
    chk("R10 high after clear", video_ok, 1);
    fill(6);
    chk("R8 live clock no alarm", pend, 4'b0000);

    $display("CHECKS %0d ERRORS %0d", checks, errs);
    $finish;
  end
endmodule